// File: doc/BRIEF.md
# Data Address Generator with Pointer Aliases

This block produces the 12-bit data-memory address for every operand access of a 16-bit-instruction core. For a direct access it joins an 8-bit offset from the instruction to a 4-bit bank number. The bank comes either from the bank-select register or, when the instruction's access flag is clear, from a fixed split. In that split, low offsets land in the bottom of memory and high offsets land in the special-function region at the top.

The block also holds three 12-bit data pointers that can each reach the whole data space. Each pointer has a group of five alias addresses in the special-function region. When the direct address lands on one of them, the access is redirected through the pointer. The alias used decides whether the pointer is used as is, stepped after the access, stepped before it, or offset by the signed working register. A write port loads any pointer. A one-level shadow keeps status, the working register and the bank number on interrupt entry, and a fast return can restore the bank number from it.

Top module: `dag_unit`

## Requirements
- R1: With access_i = 0 and offset_i below 0x80, eff_addr_o equals {4'h0, offset_i} and ind_o is 0.
- R2: With access_i = 0 and offset_i at 0x80 or above, the direct address is {4'hF, offset_i}. With access_i = 1 the direct address is {bsr_o, offset_i}. Unless an alias is hit (R4), eff_addr_o equals the direct address.
- R3: Alias groups sit at direct address 0xFE0 + 8*k for pointer k (k = 0..2). Within a group, sub-address 0 is plain, 1 is post-decrement, 2 is post-increment, 3 is pre-increment and 4 is add-W. Sub-addresses 5 to 7 are ordinary direct addresses.
- R4: On an alias hit ind_o is 1. A plain alias gives eff_addr_o = pointer and leaves the pointer unchanged.
- R5: A post-decrement alias gives eff_addr_o = pointer. When op_i is 1, the pointer holds pointer - 1 modulo 4096 after the clock edge.
- R6: A post-increment alias gives eff_addr_o = pointer. When op_i is 1, the pointer holds pointer + 1 modulo 4096 after the edge.
- R7: A pre-increment alias gives eff_addr_o = pointer + 1 modulo 4096 in the same cycle. When op_i is 1, the pointer holds that value after the edge.
- R8: An add-W alias gives eff_addr_o = pointer + sign-extended wreg_i modulo 4096, and the pointer is not changed.
- R9: ptr_we_i loads ptr_d_i into the pointer picked by ptr_sel_i at the next edge. When ptr_we_i is 1, no alias step happens in that cycle, so at most one pointer changes per cycle.
- R10: With op_i = 0, an alias hit does not change any pointer.
- R11: shd_save_i captures status_i, wreg_i and the current bank number into the shadow at the next edge. shd_status_o and shd_wreg_o show the captured values.
- R12: bsr_we_i loads bsr_d_i. fast_ret_i loads the shadowed bank number instead and wins over bsr_we_i.
- R13: After reset all pointers, the bank number and the shadow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 1 | An operand access takes place this cycle |
| offset_i | input | 8 | Instruction address offset |
| access_i | input | 1 | 0: fixed split, 1: bank-select register |
| wreg_i | input | 8 | Working register, signed for add-W |
| ptr_we_i | input | 1 | Pointer write enable |
| ptr_sel_i | input | 2 | Pointer selected for the write |
| ptr_d_i | input | 12 | Pointer write data |
| bsr_we_i | input | 1 | Bank-select write enable |
| bsr_d_i | input | 4 | Bank-select write data |
| status_i | input | 8 | Status byte for the shadow |
| shd_save_i | input | 1 | Capture the shadow (interrupt entry) |
| fast_ret_i | input | 1 | Restore the bank number from the shadow |
| eff_addr_o | output | 12 | Effective data address |
| ind_o | output | 1 | The address came through a pointer |
| ptr_o | output | 36 | Pointers, pointer k in bits 12k+11:12k |
| bsr_o | output | 4 | Bank-select register |
| shd_status_o | output | 8 | Shadowed status |
| shd_wreg_o | output | 8 | Shadowed working register |

## Verification
The assertions assume ptr_sel_i never selects a pointer index above 2 while ptr_we_i is high. They also assume that reset is applied before the first access. The stimulus draws ptr_sel_i only from 0 to 2. Half of its offsets are aimed at the alias window 0xE0 to 0xF7, with access_i mostly 0, so that every alias kind is hit often. Directed steps cover pointer wrap at 0x000 and 0xFFF, a negative working register, a write colliding with an alias step, and a fast return colliding with a bank write.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_PLUSW   = 3'd4
  } alias_mode_e;

  localparam int unsigned ALIAS_STRIDE_LG = 3;
  localparam int unsigned ALIAS_COUNT     = 5;
endpackage

// File: rtl/dag_bank_map.sv
module dag_bank_map #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BANK_W = 4,
  localparam int unsigned OFF_W = ADDR_W - BANK_W
) (
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              access_i,
  input  logic [BANK_W-1:0] bsr_i,
  output logic [ADDR_W-1:0] dir_addr_o
);
  always_comb begin
    if (access_i)               dir_addr_o = {bsr_i, offset_i};
    else if (offset_i[OFF_W-1]) dir_addr_o = {{BANK_W{1'b1}}, offset_i};
    else                        dir_addr_o = {{BANK_W{1'b0}}, offset_i};
  end
endmodule

// File: rtl/dag_alias_dec.sv
module dag_alias_dec
  import dag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NPTR       = 3,
  parameter logic [11:0] ALIAS_BASE = 12'hFE0,
  localparam int unsigned IDX_W     = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [ADDR_W-1:0] dir_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output alias_mode_e       mode_o
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] grp;

  always_comb begin
    rel    = dir_addr_i - ADDR_W'(ALIAS_BASE);
    grp    = rel >> ALIAS_STRIDE_LG;
    hit_o  = (dir_addr_i >= ADDR_W'(ALIAS_BASE)) && (grp < ADDR_W'(NPTR))
             && (32'(rel[ALIAS_STRIDE_LG-1:0]) < ALIAS_COUNT);
    idx_o  = grp[IDX_W-1:0];
    mode_o = alias_mode_e'(rel[ALIAS_STRIDE_LG-1:0]);
  end
endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NPTR   = 3,
  localparam int unsigned IDX_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            wsel_i,
  input  logic [ADDR_W-1:0]           wdata_i,
  input  logic                        upd_i,
  input  logic [IDX_W-1:0]            usel_i,
  input  logic                        dec_i,
  output logic [NPTR-1:0][ADDR_W-1:0] ptr_o
);
  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[k] <= '0;
      end else if (we_i && wsel_i == IDX_W'(k)) begin
        ptr_o[k] <= wdata_i;
      end else if (upd_i && !we_i && usel_i == IDX_W'(k)) begin
        ptr_o[k] <= dec_i ? ptr_o[k] - 1'b1 : ptr_o[k] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dag_shadow.sv
module dag_shadow #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ST_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bsr_we_i,
  input  logic [BANK_W-1:0] bsr_d_i,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [DATA_W-1:0] wreg_i,
  output logic [BANK_W-1:0] bsr_o,
  output logic [BANK_W-1:0] shd_bsr_o,
  output logic [ST_W-1:0]   shd_status_o,
  output logic [DATA_W-1:0] shd_wreg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsr_o        <= '0;
      shd_bsr_o    <= '0;
      shd_status_o <= '0;
      shd_wreg_o   <= '0;
    end else begin
      if (restore_i)     bsr_o <= shd_bsr_o;
      else if (bsr_we_i) bsr_o <= bsr_d_i;
      if (save_i) begin
        shd_bsr_o    <= bsr_o;
        shd_status_o <= status_i;
        shd_wreg_o   <= wreg_i;
      end
    end
  end
endmodule

// File: rtl/dag_unit.sv
module dag_unit
  import dag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ST_W       = 8,
  parameter int unsigned NPTR       = 3,
  parameter logic [11:0] ALIAS_BASE = 12'hFE0,
  localparam int unsigned OFF_W     = ADDR_W - BANK_W,
  localparam int unsigned IDX_W     = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   op_i,
  input  logic [OFF_W-1:0]       offset_i,
  input  logic                   access_i,
  input  logic [DATA_W-1:0]      wreg_i,
  input  logic                   ptr_we_i,
  input  logic [IDX_W-1:0]       ptr_sel_i,
  input  logic [ADDR_W-1:0]      ptr_d_i,
  input  logic                   bsr_we_i,
  input  logic [BANK_W-1:0]      bsr_d_i,
  input  logic [ST_W-1:0]        status_i,
  input  logic                   shd_save_i,
  input  logic                   fast_ret_i,
  output logic [ADDR_W-1:0]      eff_addr_o,
  output logic                   ind_o,
  output logic [NPTR*ADDR_W-1:0] ptr_o,
  output logic [BANK_W-1:0]      bsr_o,
  output logic [ST_W-1:0]        shd_status_o,
  output logic [DATA_W-1:0]      shd_wreg_o
);
  logic [ADDR_W-1:0]           dir_addr;
  logic                        hit;
  logic [IDX_W-1:0]            idx;
  alias_mode_e                 mode;
  logic [NPTR-1:0][ADDR_W-1:0] ptrs;
  logic [ADDR_W-1:0]           cur_ptr;
  logic [ADDR_W-1:0]           w_ext;
  logic                        step;
  logic [BANK_W-1:0]           shd_bsr;

  dag_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map (
    .offset_i(offset_i), .access_i(access_i), .bsr_i(bsr_o), .dir_addr_o(dir_addr)
  );

  dag_alias_dec #(.ADDR_W(ADDR_W), .NPTR(NPTR), .ALIAS_BASE(ALIAS_BASE)) u_dec (
    .dir_addr_i(dir_addr), .hit_o(hit), .idx_o(idx), .mode_o(mode)
  );

  assign cur_ptr = ptrs[idx];
  assign w_ext   = {{(ADDR_W-DATA_W){wreg_i[DATA_W-1]}}, wreg_i};
  assign step    = op_i && hit &&
                   (mode == AM_POSTDEC || mode == AM_POSTINC || mode == AM_PREINC);

  always_comb begin
    eff_addr_o = dir_addr;
    if (hit) begin
      unique case (mode)
        AM_PREINC: eff_addr_o = cur_ptr + 1'b1;
        AM_PLUSW:  eff_addr_o = cur_ptr + w_ext;
        default:   eff_addr_o = cur_ptr;
      endcase
    end
  end
  assign ind_o = hit;

  dag_ptr_file #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_ptrs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(ptr_we_i), .wsel_i(ptr_sel_i), .wdata_i(ptr_d_i),
    .upd_i(step), .usel_i(idx), .dec_i(mode == AM_POSTDEC),
    .ptr_o(ptrs)
  );
  assign ptr_o = ptrs;

  dag_shadow #(.BANK_W(BANK_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bsr_we_i(bsr_we_i), .bsr_d_i(bsr_d_i),
    .save_i(shd_save_i), .restore_i(fast_ret_i),
    .status_i(status_i), .wreg_i(wreg_i),
    .bsr_o(bsr_o), .shd_bsr_o(shd_bsr),
    .shd_status_o(shd_status_o), .shd_wreg_o(shd_wreg_o)
  );
endmodule

// File: rtl/dag_unit_chk.sv
module dag_unit_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NPTR   = 3,
  localparam int unsigned OFF_W = ADDR_W - BANK_W,
  localparam int unsigned IDX_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   op_i,
  input logic [OFF_W-1:0]       offset_i,
  input logic                   access_i,
  input logic [DATA_W-1:0]      wreg_i,
  input logic                   ptr_we_i,
  input logic [IDX_W-1:0]       ptr_sel_i,
  input logic [ADDR_W-1:0]      ptr_d_i,
  input logic                   shd_save_i,
  input logic                   fast_ret_i,
  input logic [ADDR_W-1:0]      eff_addr_o,
  input logic                   ind_o,
  input logic [NPTR*ADDR_W-1:0] ptr_o,
  input logic [BANK_W-1:0]      bsr_o,
  input logic [BANK_W-1:0]      shd_bsr,
  input logic [DATA_W-1:0]      shd_wreg_o
);
  logic [NPTR*ADDR_W-1:0] prev_ptr;
  logic [NPTR-1:0]        changed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_ptr <= '0;
    else         prev_ptr <= ptr_o;
  end

  always_comb
    for (int k = 0; k < NPTR; k++)
      changed[k] = ptr_o[k*ADDR_W +: ADDR_W] != prev_ptr[k*ADDR_W +: ADDR_W];

  AST_LOW_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_i && !offset_i[OFF_W-1]) |-> (eff_addr_o == {{BANK_W{1'b0}}, offset_i} && !ind_o)); // R1

  AST_SFR_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_i && offset_i[OFF_W-1] && !ind_o) |-> (eff_addr_o == {{BANK_W{1'b1}}, offset_i})); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i && !ptr_we_i) |=> $stable(ptr_o)); // R10

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> (ADDR_W'(ptr_o >> (ADDR_W * $past(ptr_sel_i))) == $past(ptr_d_i))); // R9

  AST_ONE_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(changed) <= 1); // R9

  AST_SHADOW_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shd_save_i |=> (shd_wreg_o == $past(wreg_i))); // R11

  AST_FAST_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_ret_i |=> (bsr_o == $past(shd_bsr))); // R12
endmodule

bind dag_unit dag_unit_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .NPTR(NPTR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .offset_i(offset_i), .access_i(access_i),
  .wreg_i(wreg_i), .ptr_we_i(ptr_we_i), .ptr_sel_i(ptr_sel_i), .ptr_d_i(ptr_d_i),
  .shd_save_i(shd_save_i), .fast_ret_i(fast_ret_i), .eff_addr_o(eff_addr_o),
  .ind_o(ind_o), .ptr_o(ptr_o), .bsr_o(bsr_o), .shd_bsr(shd_bsr), .shd_wreg_o(shd_wreg_o)
);

// File: tb/dag_unit_test.sv
module dag_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_i = 1'b0;
  logic [7:0]  offset_i = '0;
  logic        access_i = 1'b0;
  logic [7:0]  wreg_i = '0;
  logic        ptr_we_i = 1'b0;
  logic [1:0]  ptr_sel_i = '0;
  logic [11:0] ptr_d_i = '0;
  logic        bsr_we_i = 1'b0;
  logic [3:0]  bsr_d_i = '0;
  logic [7:0]  status_i = '0;
  logic        shd_save_i = 1'b0;
  logic        fast_ret_i = 1'b0;
  logic [11:0] eff_addr_o;
  logic        ind_o;
  logic [35:0] ptr_o;
  logic [3:0]  bsr_o;
  logic [7:0]  shd_status_o;
  logic [7:0]  shd_wreg_o;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_ptr [3];
  logic [3:0]  m_bsr, m_sbsr;
  logic [7:0]  m_sst, m_sw;

  always #5 clk_i = ~clk_i;

  dag_unit uut (.*);

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] dir_of(logic [7:0] off, logic acc, logic [3:0] b);
    if (acc) return {b, off};
    return off >= 8'h80 ? {4'hF, off} : {4'h0, off};
  endfunction

  // returns {hit, idx, mode}
  function automatic logic [5:0] alias_of(logic [11:0] d);
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 5; m++)
        if (d == 12'hFE0 + 12'(8 * k + m)) return {1'b1, 2'(k), 3'(m)};
    return 6'd0;
  endfunction

  // drive one cycle, check address now and model state after the edge
  task automatic step(logic op, logic [7:0] off, logic acc, logic [7:0] w,
                      logic we, logic [1:0] sel, logic [11:0] d,
                      logic bwe, logic [3:0] bd, logic [7:0] st, logic sv, logic fr);
    logic [11:0] dir, e;
    logic [5:0]  a;
    string tag;
    op_i = op; offset_i = off; access_i = acc; wreg_i = w; ptr_we_i = we;
    ptr_sel_i = sel; ptr_d_i = d; bsr_we_i = bwe; bsr_d_i = bd; status_i = st;
    shd_save_i = sv; fast_ret_i = fr;
    #1;
    dir = dir_of(off, acc, m_bsr);
    a = alias_of(dir);
    e = dir;
    tag = acc ? "R2" : (off[7] ? "R2" : "R1");
    if (a[5]) begin
      case (a[2:0])
        3'd0: begin e = m_ptr[a[4:3]]; tag = "R4"; end
        3'd1: begin e = m_ptr[a[4:3]]; tag = "R5"; end
        3'd2: begin e = m_ptr[a[4:3]]; tag = "R6"; end
        3'd3: begin e = m_ptr[a[4:3]] + 12'd1; tag = "R7"; end
        default: begin e = m_ptr[a[4:3]] + {{4{w[7]}}, w}; tag = "R8"; end
      endcase
    end
    chk(tag, eff_addr_o, e);
    chk(a[5] ? "R3" : "R3 direct", ind_o, a[5]);
    // model update
    if (we) m_ptr[sel] = d;
    else if (op && a[5]) begin
      if (a[2:0] == 3'd1) m_ptr[a[4:3]] = m_ptr[a[4:3]] - 12'd1;
      if (a[2:0] == 3'd2 || a[2:0] == 3'd3) m_ptr[a[4:3]] = m_ptr[a[4:3]] + 12'd1;
    end
    if (sv) begin m_sbsr_next(); m_sst = st; m_sw = w; end
    else m_hold = m_sbsr;
    if (fr) m_bsr = m_sbsr;
    else if (bwe) m_bsr = bd;
    m_sbsr = m_hold;
    @(negedge clk_i);
    chk(we ? "R9" : (op ? "R5 R6 R7 ptr" : "R10"), ptr_o, {m_ptr[2], m_ptr[1], m_ptr[0]});
    chk(fr ? "R12 fast" : "R12", bsr_o, m_bsr);
    chk("R11", {shd_status_o, shd_wreg_o}, {m_sst, m_sw});
  endtask

  logic [3:0] m_hold;
  function automatic void m_sbsr_next();
    m_hold = m_bsr;
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) m_ptr[k] = '0;
    m_bsr = '0; m_sbsr = '0; m_sst = '0; m_sw = '0; m_hold = '0;
    repeat (3) @(negedge clk_i);
    chk("R13", {ptr_o, bsr_o, shd_status_o, shd_wreg_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R5 wrap below zero on pointer 0
    step(1, 8'hE1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 wrap", ptr_o[11:0], 12'hFFF);
    // R6 wrap above 0xFFF on pointer 0
    step(1, 8'hE2, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 wrap", ptr_o[11:0], 12'h000);
    // R8 negative W on pointer 1
    step(0, 8'h00, 0, 8'h00, 1, 1, 12'h010, 0, 0, 0, 0, 0);
    step(1, 8'hEC, 0, 8'h80, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 neg", eff_addr_o, 12'hF90);
    // R7 pre-increment on pointer 2 from 0xFFF
    step(0, 8'h00, 0, 8'h00, 1, 2, 12'hFFF, 0, 0, 0, 0, 0);
    step(1, 8'hF3, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 write collides with step
    step(1, 8'hF2, 0, 8'h00, 1, 2, 12'h123, 0, 0, 0, 0, 0);
    // R10 alias without op
    step(0, 8'hF1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 sub-address 5 is direct
    step(1, 8'hE5, 0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11/R12 shadow and fast return colliding with bank write
    step(0, 8'h10, 1, 8'h5A, 0, 0, 0, 1, 4'hF, 0, 0, 0);
    step(1, 8'hE2, 1, 8'h3C, 0, 0, 0, 0, 0, 8'hA5, 1, 0);
    step(0, 8'h10, 1, 8'h00, 0, 0, 0, 1, 4'h3, 0, 0, 0);
    step(0, 8'h10, 1, 8'h00, 0, 0, 0, 1, 4'h7, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] off;
      off = ($urandom % 2) ? 8'(8'hE0 + $urandom % 24) : 8'($urandom);
      step($urandom % 4 != 0, off, ($urandom % 4) == 0, 8'($urandom),
           ($urandom % 8) == 0, 2'($urandom % 3), 12'($urandom),
           ($urandom % 8) == 0, 4'($urandom), 8'($urandom),
           ($urandom % 10) == 0, ($urandom % 10) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule